// File: doc/BRIEF.md
# DRAM Request Scheduler with Open-Page Address Mapping

This block sits between the last-level cache miss path and a single-channel DRAM command interface. Each incoming read or write carries a physical address and a tag. The block splits the address into row, rank, bank and column fields, then files the request into a small queue owned by its bank. Rank and bank together select one of eight banks. Each cycle the block may issue one queued request on its issue port. The issue port reports rank, bank, row, column, the tag, the direction, and whether the access found its row already open.

Each bank remembers the single row held in its row buffer. In the default first-ready mode, a request that targets the open row of its bank goes ahead of older requests that would need a new row. Among requests of equal standing, the oldest goes first. A configuration input switches to plain arrival order. Writes wait while any read is queued. The exception is when the write buffer is full: writes then compete normally, so the queues cannot deadlock. Opening a new row costs a fixed number of idle issue cycles.

Top module: `dram_sched`

## Requirements
- R1: The request address is split by bit position, from most to least significant: row [23:14], rank [13], bank [12:11], column [10:7], channel [6], block offset [5:0]. The channel and offset bits do not affect scheduling.
- R2: When the scheduler is idle and a request is accepted at a clock edge, `iss_valid` is high for exactly one cycle after the next edge. In that cycle it carries the request's rank, bank, row, column, tag and direction.
- R3: Each bank queue holds 4 requests. `req_ready` is low for a request whose bank queue is full, and stays high for a request to another bank.
- R4: When `cfg_fcfs` is 0, a queued request to the open row of its bank is issued before older queued requests that miss.
- R5: Among requests of equal standing (all hits or all misses), the one that arrived first is issued first.
- R6: When `cfg_fcfs` is 1, the oldest eligible request is issued first, whatever the row state.
- R7: After reset every bank's row is closed, so the first access to a bank reports `iss_hit` = 0. A miss issue opens its row. A later issue to the same bank and row reports `iss_hit` = 1.
- R8: After a miss issue, the next issue comes exactly PENALTY+1 = 9 cycles later when work is waiting. After a hit issue, the next issue may come in the very next cycle.
- R9: A queued write is not issued while any read is queued, unless the write buffer is full.
- R10: The write buffer holds 4 writes in total. While it is full, `req_ready` is low for writes. Queued writes then become eligible alongside reads, and the oldest request is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_fcfs | input | 1 | 1 = plain arrival order, 0 = open-row hits first |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be accepted |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 24 | Physical address |
| req_tag | input | 4 | Request identifier |
| iss_valid | output | 1 | Issue slot holds a request |
| iss_write | output | 1 | Issued request is a write |
| iss_rank | output | 1 | Issued rank |
| iss_bank | output | 2 | Issued bank within rank |
| iss_row | output | 10 | Issued row |
| iss_col | output | 4 | Issued column |
| iss_hit | output | 1 | Row was already open |
| iss_tag | output | 4 | Tag of issued request |

## Verification
Each scenario first issues one miss, which holds the issue port idle for the row-open penalty. During that window a chosen mix is queued, and the bench then reads the issue order. One mix places an older row miss ahead of younger hits in the same bank. It is run in both modes, which tells hit-first ordering apart from plain arrival order. A write queued before a read shows the read priority. Four writes plus a read show the drain rule that applies when the write buffer is full. Filling one bank's queue separates the per-bank ready decision from the other banks. A lone request with a distinct field in every position checks the address split, the one-cycle latency and the hit flag.

// File: rtl/dsch_pkg.sv
package dsch_pkg;
    localparam int OFS_W   = 6;
    localparam int CHN_W   = 1;
    localparam int COL_W   = 4;
    localparam int BNK_W   = 2;
    localparam int RNK_W   = 1;
    localparam int ROW_W   = 10;
    localparam int TAG_W   = 4;
    localparam int STAMP_W = 16;
    localparam int ADDR_W  = ROW_W + RNK_W + BNK_W + COL_W + CHN_W + OFS_W;
    localparam int BID_W   = RNK_W + BNK_W;
    localparam int NBANK   = 1 << BID_W;

    typedef struct packed {
        logic               vld;
        logic               wr;
        logic [ROW_W-1:0]   row;
        logic [COL_W-1:0]   col;
        logic [TAG_W-1:0]   tag;
        logic [STAMP_W-1:0] stamp;
    } qent_t;
endpackage

// File: rtl/dsch_addr_map.sv
module dsch_addr_map
    import dsch_pkg::*;
(
    input  logic [ADDR_W-1:0] addr_i,
    output logic [BID_W-1:0]  bid_o,
    output logic [ROW_W-1:0]  row_o,
    output logic [COL_W-1:0]  col_o
);
    localparam int COL_LSB = OFS_W + CHN_W;
    localparam int BID_LSB = COL_LSB + COL_W;
    localparam int ROW_LSB = BID_LSB + BID_W;

    // open-page layout: row | rank | bank | column | channel | offset
    assign row_o = addr_i[ROW_LSB +: ROW_W];
    assign bid_o = addr_i[BID_LSB +: BID_W];
    assign col_o = addr_i[COL_LSB +: COL_W];
endmodule

// File: rtl/dsch_bank_queue.sv
module dsch_bank_queue
    import dsch_pkg::*;
#(
    parameter int QDEPTH = 4,
    localparam int SLOT_W = (QDEPTH > 1) ? $clog2(QDEPTH) : 1
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     push_i,
    input  qent_t                    push_ent_i,
    input  logic                     pop_i,
    input  logic [SLOT_W-1:0]        pop_slot_i,
    output qent_t [QDEPTH-1:0]       slots_o,
    output logic                     full_o
);
    typedef struct packed {
        qent_t [QDEPTH-1:0] ent;
    } st_t;

    st_t  st_q, st_d;
    logic placed;

    always_comb begin
        st_d   = st_q;
        placed = 1'b0;
        full_o = 1'b1;
        for (int s = 0; s < QDEPTH; s++) begin
            if (!st_q.ent[s].vld) full_o = 1'b0;
        end
        if (pop_i) st_d.ent[pop_slot_i].vld = 1'b0;
        if (push_i) begin
            for (int s = 0; s < QDEPTH; s++) begin
                if (!placed && !st_q.ent[s].vld) begin
                    st_d.ent[s] = push_ent_i;
                    placed      = 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign slots_o = st_q.ent;

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        push_i |-> !full_o); // R3
    AST_POP_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
        pop_i |-> st_q.ent[pop_slot_i].vld); // R2
endmodule

// File: rtl/dsch_picker.sv
module dsch_picker
    import dsch_pkg::*;
#(
    parameter int QDEPTH = 4,
    localparam int NENT  = NBANK * QDEPTH,
    localparam int IDX_W = $clog2(NENT)
) (
    input  qent_t [NENT-1:0]             ents_i,
    input  logic [NBANK-1:0][ROW_W-1:0]  open_row_i,
    input  logic [NBANK-1:0]             open_vld_i,
    input  logic                         fcfs_i,
    input  logic                         wr_ok_i,
    input  logic [STAMP_W-1:0]           now_i,
    output logic                         sel_vld_o,
    output logic [IDX_W-1:0]             sel_idx_o,
    output logic                         sel_hit_o
);
    logic [STAMP_W-1:0] best_age, age;
    logic               best_pri, pri, hit, elig;

    always_comb begin
        sel_vld_o = 1'b0;
        sel_idx_o = '0;
        sel_hit_o = 1'b0;
        best_age  = '0;
        best_pri  = 1'b0;
        age       = '0;
        pri       = 1'b0;
        hit       = 1'b0;
        elig      = 1'b0;
        for (int i = 0; i < NENT; i++) begin
            elig = ents_i[i].vld && (!ents_i[i].wr || wr_ok_i);
            hit  = open_vld_i[i / QDEPTH] && (open_row_i[i / QDEPTH] == ents_i[i].row);
            pri  = hit && !fcfs_i;
            age  = now_i - ents_i[i].stamp;
            if (elig && (!sel_vld_o || (pri && !best_pri) ||
                         ((pri == best_pri) && (age > best_age)))) begin
                sel_vld_o = 1'b1;
                sel_idx_o = IDX_W'(i);
                sel_hit_o = hit;
                best_age  = age;
                best_pri  = pri;
            end
        end
    end
endmodule

// File: rtl/dram_sched.sv
module dram_sched
    import dsch_pkg::*;
#(
    parameter int QDEPTH   = 4,
    parameter int PENALTY  = 8,
    parameter int WBUF_MAX = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_fcfs,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [TAG_W-1:0]  req_tag,
    output logic              iss_valid,
    output logic              iss_write,
    output logic [RNK_W-1:0]  iss_rank,
    output logic [BNK_W-1:0]  iss_bank,
    output logic [ROW_W-1:0]  iss_row,
    output logic [COL_W-1:0]  iss_col,
    output logic              iss_hit,
    output logic [TAG_W-1:0]  iss_tag
);
    localparam int SLOT_W = (QDEPTH > 1) ? $clog2(QDEPTH) : 1;
    localparam int NENT   = NBANK * QDEPTH;
    localparam int IDX_W  = $clog2(NENT);
    localparam int PEN_W  = $clog2(PENALTY + 1);
    localparam int WC_W   = $clog2(WBUF_MAX + 1);

    typedef struct packed {
        logic [NBANK-1:0][ROW_W-1:0] orow;
        logic [NBANK-1:0]            ovld;
        logic [PEN_W-1:0]            busy;
        logic [STAMP_W-1:0]          now;
        logic [WC_W-1:0]             wcnt;
        logic                        ivld;
        logic                        iwr;
        logic [BID_W-1:0]            ibid;
        logic [ROW_W-1:0]            irow;
        logic [COL_W-1:0]            icol;
        logic                        ihit;
        logic [TAG_W-1:0]            itag;
    } st_t;

    st_t st_q, st_d;

    logic [BID_W-1:0]              req_bid;
    logic [ROW_W-1:0]              req_row;
    logic [COL_W-1:0]              req_col;
    qent_t                         push_ent;
    qent_t [NBANK-1:0][QDEPTH-1:0] qslots;
    logic [NBANK-1:0]              qfull;
    logic                          accept, wr_full, rd_pend, wr_ok, go;
    logic                          sel_vld, sel_hit;
    logic [IDX_W-1:0]              sel_idx;
    logic [BID_W-1:0]              sel_bank;
    logic [SLOT_W-1:0]             sel_slot;
    qent_t                         sel_ent;

    dsch_addr_map u_map (
        .addr_i (req_addr),
        .bid_o  (req_bid),
        .row_o  (req_row),
        .col_o  (req_col)
    );

    assign wr_full   = (st_q.wcnt >= WC_W'(WBUF_MAX));
    assign req_ready = !qfull[req_bid] && !(req_write && wr_full);
    assign accept    = req_valid && req_ready;
    assign push_ent  = '{vld: 1'b1, wr: req_write, row: req_row, col: req_col,
                         tag: req_tag, stamp: st_q.now};

    assign sel_bank = sel_idx[IDX_W-1 -: BID_W];
    assign sel_slot = sel_idx[SLOT_W-1:0];
    assign sel_ent  = qslots[sel_bank][sel_slot];
    assign go       = sel_vld && (st_q.busy == '0);

    generate
        for (genvar b = 0; b < NBANK; b++) begin : g_bank
            dsch_bank_queue #(.QDEPTH(QDEPTH)) u_q (
                .clk        (clk),
                .rst_n      (rst_n),
                .push_i     (accept && (req_bid == BID_W'(b))),
                .push_ent_i (push_ent),
                .pop_i      (go && (sel_bank == BID_W'(b))),
                .pop_slot_i (sel_slot),
                .slots_o    (qslots[b]),
                .full_o     (qfull[b])
            );
        end
    endgenerate

    always_comb begin
        rd_pend = 1'b0;
        for (int b = 0; b < NBANK; b++) begin
            for (int s = 0; s < QDEPTH; s++) begin
                if (qslots[b][s].vld && !qslots[b][s].wr) rd_pend = 1'b1;
            end
        end
    end
    assign wr_ok = !rd_pend || wr_full;

    dsch_picker #(.QDEPTH(QDEPTH)) u_pick (
        .ents_i     (qslots),
        .open_row_i (st_q.orow),
        .open_vld_i (st_q.ovld),
        .fcfs_i     (cfg_fcfs),
        .wr_ok_i    (wr_ok),
        .now_i      (st_q.now),
        .sel_vld_o  (sel_vld),
        .sel_idx_o  (sel_idx),
        .sel_hit_o  (sel_hit)
    );

    always_comb begin
        st_d      = st_q;
        st_d.now  = st_q.now + STAMP_W'(accept);
        st_d.wcnt = st_q.wcnt + WC_W'(accept && req_write) - WC_W'(go && sel_ent.wr);
        st_d.ivld = go;
        if (go && !sel_hit)        st_d.busy = PEN_W'(PENALTY);
        else if (st_q.busy != '0)  st_d.busy = st_q.busy - 1'b1;
        if (go) begin
            st_d.iwr  = sel_ent.wr;
            st_d.ibid = sel_bank;
            st_d.irow = sel_ent.row;
            st_d.icol = sel_ent.col;
            st_d.ihit = sel_hit;
            st_d.itag = sel_ent.tag;
            if (!sel_hit) begin
                st_d.orow[sel_bank] = sel_ent.row;
                st_d.ovld[sel_bank] = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign iss_valid = st_q.ivld;
    assign iss_write = st_q.iwr;
    assign iss_rank  = st_q.ibid[BID_W-1 -: RNK_W];
    assign iss_bank  = st_q.ibid[BNK_W-1:0];
    assign iss_row   = st_q.irow;
    assign iss_col   = st_q.icol;
    assign iss_hit   = st_q.ihit;
    assign iss_tag   = st_q.itag;

    AST_PENALTY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.busy != '0) |=> !iss_valid); // R8
    AST_MISS_OPENS_ROW: assert property (@(posedge clk) disable iff (!rst_n)
        (iss_valid && !iss_hit) |-> (st_q.ovld[st_q.ibid] && st_q.orow[st_q.ibid] == iss_row)); // R7
    AST_WRITE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (iss_valid && iss_write) |-> $past(!rd_pend || wr_full)); // R9
    AST_WBUF_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.wcnt <= WC_W'(WBUF_MAX)); // R10
endmodule

// File: tb/dram_sched_bench.sv
module dram_sched_bench;
    import dsch_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int PEN        = 8;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              cfg_fcfs = 1'b0;
    logic              req_valid = 1'b0;
    logic              req_ready;
    logic              req_write = 1'b0;
    logic [ADDR_W-1:0] req_addr = '0;
    logic [TAG_W-1:0]  req_tag = '0;
    logic              iss_valid, iss_write, iss_hit;
    logic [RNK_W-1:0]  iss_rank;
    logic [BNK_W-1:0]  iss_bank;
    logic [ROW_W-1:0]  iss_row;
    logic [COL_W-1:0]  iss_col;
    logic [TAG_W-1:0]  iss_tag;

    int n_chk = 0, n_err = 0, cyc = 0, n_log = 0, acc_cyc = 0;
    int lg_tag[64], lg_hit[64], lg_wr[64], lg_cyc[64], lg_row[64], lg_col[64], lg_rank[64], lg_bank[64];

    dram_sched u_dram_sched (
        .clk(clk), .rst_n(rst_n), .cfg_fcfs(cfg_fcfs),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_addr(req_addr), .req_tag(req_tag),
        .iss_valid(iss_valid), .iss_write(iss_write), .iss_rank(iss_rank),
        .iss_bank(iss_bank), .iss_row(iss_row), .iss_col(iss_col),
        .iss_hit(iss_hit), .iss_tag(iss_tag)
    );

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    always @(negedge clk) begin
        if (rst_n && iss_valid && n_log < 64) begin
            lg_tag[n_log]  = int'(iss_tag);
            lg_hit[n_log]  = int'(iss_hit);
            lg_wr[n_log]   = int'(iss_write);
            lg_cyc[n_log]  = cyc;
            lg_row[n_log]  = int'(iss_row);
            lg_col[n_log]  = int'(iss_col);
            lg_rank[n_log] = int'(iss_rank);
            lg_bank[n_log] = int'(iss_bank);
            n_log = n_log + 1;
        end
    end

    task automatic chk(string req, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic logic [ADDR_W-1:0] mk(int rk, int bk, int rw, int cl);
        return {ROW_W'(rw), RNK_W'(rk), BNK_W'(bk), COL_W'(cl), CHN_W'(0), OFS_W'(0)};
    endfunction

    // called at a negedge; returns at the next negedge after the accepting edge
    task automatic send(logic wr, logic [ADDR_W-1:0] a, int tag);
        req_valid = 1'b1;
        req_write = wr;
        req_addr  = a;
        req_tag   = TAG_W'(tag);
        @(negedge clk);
        acc_cyc   = cyc;
        req_valid = 1'b0;
    endtask

    task automatic probe(string req, logic wr, logic [ADDR_W-1:0] a, int exp);
        req_valid = 1'b0;
        req_write = wr;
        req_addr  = a;
        #1;
        chk(req, int'(req_ready), exp);
    endtask

    task automatic wait_n(int n);
        for (int k = 0; k < 300 && n_log < n; k++) @(negedge clk);
    endtask

    task automatic settle();
        repeat (40) @(negedge clk);
        n_log = 0;
    endtask

    task automatic t_reset();
        chk("R3 reset ready", int'(req_ready), 1);
        chk("R2 reset issue idle", int'(iss_valid), 0);
    endtask

    task automatic t_decode();
        int a0;
        send(1'b0, {10'h2A5, 1'b1, 2'd2, 4'd9, 1'b1, 6'h13}, 3);
        a0 = acc_cyc;
        wait_n(1);
        chk("R2 issue count", n_log, 1);
        chk("R1 row", lg_row[0], 'h2A5);
        chk("R1 rank", lg_rank[0], 1);
        chk("R1 bank", lg_bank[0], 2);
        chk("R1 col", lg_col[0], 9);
        chk("R2 tag", lg_tag[0], 3);
        chk("R2 dir", lg_wr[0], 0);
        chk("R2 latency", lg_cyc[0], a0 + 1);
        chk("R7 first access miss", lg_hit[0], 0);
        repeat (20) @(negedge clk);
        send(1'b0, {10'h2A5, 1'b1, 2'd2, 4'd4, 1'b0, 6'h00}, 4);
        a0 = acc_cyc;
        wait_n(2);
        chk("R7 reopen hit", lg_hit[1], 1);
        chk("R2 hit latency", lg_cyc[1], a0 + 1);
        chk("R2 hit col", lg_col[1], 4);
        settle();
    endtask

    task automatic t_frfcfs();
        cfg_fcfs = 1'b0;
        send(1'b0, mk(0, 0, 5, 0), 1);
        send(1'b0, mk(0, 0, 7, 0), 2);
        send(1'b0, mk(0, 0, 5, 1), 3);
        send(1'b0, mk(0, 0, 5, 2), 4);
        wait_n(4);
        chk("R4 count", n_log, 4);
        chk("R4 hit first", lg_tag[1], 3);
        chk("R5 older hit next", lg_tag[2], 4);
        chk("R4 miss last", lg_tag[3], 2);
        chk("R7 hit flag", lg_hit[1], 1);
        chk("R7 miss flag", lg_hit[3], 0);
        chk("R8 miss gap", lg_cyc[1] - lg_cyc[0], PEN + 1);
        chk("R8 hit back-to-back", lg_cyc[2] - lg_cyc[1], 1);
        settle();
    endtask

    task automatic t_fcfs();
        cfg_fcfs = 1'b1;
        send(1'b0, mk(0, 1, 3, 0), 5);
        send(1'b0, mk(0, 1, 7, 0), 6);
        send(1'b0, mk(0, 1, 3, 1), 7);
        wait_n(3);
        chk("R6 count", n_log, 3);
        chk("R6 oldest first", lg_tag[1], 6);
        chk("R6 then next", lg_tag[2], 7);
        chk("R6 row closed again", lg_hit[2], 0);
        cfg_fcfs = 1'b0;
        settle();
    endtask

    task automatic t_write_held();
        send(1'b0, mk(0, 2, 1, 0), 8);
        send(1'b1, mk(0, 3, 0, 0), 9);
        send(1'b0, mk(0, 2, 1, 3), 10);
        wait_n(3);
        chk("R9 count", n_log, 3);
        chk("R9 read before older write", lg_tag[1], 10);
        chk("R9 write last", lg_tag[2], 9);
        chk("R9 write dir", lg_wr[2], 1);
        settle();
    endtask

    task automatic t_wbuf_full();
        send(1'b0, mk(1, 0, 1, 0), 11);
        for (int k = 0; k < 4; k++) send(1'b1, mk(1, 1, 0, k), 12 + k);
        probe("R10 write refused when full", 1'b1, mk(1, 3, 0, 0), 0);
        probe("R10 read still accepted", 1'b0, mk(1, 3, 0, 0), 1);
        send(1'b0, mk(1, 0, 2, 0), 1);
        wait_n(6);
        chk("R10 count", n_log, 6);
        chk("R10 drain oldest write", lg_tag[1], 12);
        chk("R9 read once below full", lg_tag[2], 1);
        chk("R10 remaining write", lg_tag[3], 13);
        chk("R10 last write", lg_tag[5], 15);
        settle();
    endtask

    task automatic t_queue_full();
        send(1'b0, mk(0, 0, 1, 0), 2);
        for (int k = 0; k < 4; k++) send(1'b0, mk(0, 0, 3, k), 3 + k);
        probe("R3 full bank refused", 1'b0, mk(0, 0, 3, 0), 0);
        probe("R3 other bank accepted", 1'b0, mk(0, 1, 3, 0), 1);
        wait_n(5);
        chk("R3 count", n_log, 5);
        chk("R3 drain order", lg_tag[4], 6);
        probe("R3 ready after drain", 1'b0, mk(0, 0, 3, 0), 1);
        settle();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_decode();
        t_frfcfs();
        t_fcfs();
        t_write_held();
        t_wbuf_full();
        t_queue_full();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 100000);
        n_chk++;
        n_err++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule